// File: doc/BRIEF.md
# Ethernet Receive Frame Error Checker

The block watches a bit-serial Ethernet receive stream, one bit per clock when `rx_valid_i` is high, with `rx_eof_i` marking the last bit of a frame. It counts bits into octets and runs a serial CRC-32 over the frame. It also keeps a copy of the CRC value taken at each complete octet boundary. When the frame closes, the block judges the frame on that boundary value. Any trailing bits that do not fill an octet (one to seven dribbling bits) are therefore accepted and take no part in the verdict.

Each closed frame produces a one-cycle `done_o` pulse and a status word. The status word holds the complete-octet length, the dribble count, and flags for short frame, alignment error, CRC error and delivery. A frame shorter than `min_len_i` octets is discarded unless `short_ok_i` is set. Delivered frames also raise `rx_evt_o`. Two saturating counters record CRC errors and alignment errors on delivered frames. After any frame with a failing CRC, the receiver goes into hunt mode and ignores input until the stream goes idle for a cycle.

Top module: `eth_rx_err_chk`

## Requirements
- R1: A frame whose CRC-32 (polynomial 0x04C11DB7, register preset to all ones, bits taken least significant first, FCS included) leaves residue 0xC704DD7B after its last complete octet and ends octet-aligned gives, one clock after the edge that samples its final bit, a one-cycle `done_o` with accept=1, crc_err=0, align_err=0, and length equal to the number of complete octets including the FCS.
- R2: A frame with 1 to 7 bits after its last complete octet, whose CRC at that octet boundary is good, reports no error; the dribble field holds the number of extra bits and the length counts only complete octets.
- R3: A frame that ends non-aligned with a bad boundary CRC sets both align_err and crc_err; only the alignment counter increments.
- R4: An octet-aligned frame with a bad CRC sets crc_err with align_err=0, and the CRC error counter increments.
- R5: `rx_evt_o` pulses in the same cycle as `done_o` for every delivered frame, errored or not, and never for a discarded frame.
- R6: After a frame with a bad boundary CRC, valid bits are ignored (no `done_o`, no counter change) until a cycle with `rx_valid_i` low. After a good frame, a frame that starts on the very next cycle is received normally.
- R7: With `short_ok_i`=0, a frame whose complete-octet length is below `min_len_i` closes with accept=0 and short=1. It raises no `rx_evt_o` and changes no counter.
- R8: With `short_ok_i`=1, a short frame is delivered with short=1 and accept=1, and its errors are counted.
- R9: Each error counter is CNT_W bits wide, adds one per counted error, and holds at its all-ones value instead of wrapping.
- R10: `cnt_clr_i` zeroes both counters on the next edge and wins over a simultaneous increment.
- R11: Status word layout: bit 0 accept, bit 1 crc_err, bit 2 align_err, bit 3 short, bits 6:4 dribble count, bits 22:7 length. The word holds its value until the next frame closes. After reset the word, `done_o`, `rx_evt_o` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial receive data bit |
| rx_valid_i | input | 1 | `rx_bit_i` carries a bit this cycle |
| rx_eof_i | input | 1 | This valid bit is the last of the frame |
| short_ok_i | input | 1 | 1 = deliver frames below the minimum length |
| min_len_i | input | 16 | Minimum frame length in octets |
| cnt_clr_i | input | 1 | Zero both error counters |
| done_o | output | 1 | One-cycle pulse: a frame has closed and `stat_o` is new |
| rx_evt_o | output | 1 | One-cycle receive-frame event for a delivered frame |
| stat_o | output | 23 | Status of the last closed frame |
| crc_cnt_o | output | CNT_W | Saturating CRC error counter |
| aln_cnt_o | output | CNT_W | Saturating alignment error counter |

## Verification
The hardest case to reach from the ports is hunt mode with no idle gap after a failing frame. Another frame arrives back-to-back, and it must disappear entirely while an identical stream after a good frame is received. The bench builds such streams bit by bit, with FCS fields computed arithmetically in reflected form. It sends a failing frame, a discarded follower and a gapped frame, and counts closures exactly. Dribble counts of every value from 1 to 7 are swept over frames with good and corrupted FCS. A small counter width lets single-bit errored frames drive the alignment counter into saturation, and a clear pulse lands on the same edge as a counted error.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  localparam int LEN_W = 16;
  localparam int CRC_W = 32;
  localparam int DRIB_W = 3;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;
  localparam logic [CRC_W-1:0] CRC_GOOD = 32'hC704_DD7B;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [DRIB_W-1:0] drib;
    logic              short_f;
    logic              align_err;
    logic              crc_err;
    logic              accept;
  } rx_stat_t;

  localparam int STAT_W = $bits(rx_stat_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HUNT = 2'd2
  } rx_state_e;
endpackage

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
  import eth_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic             oct_end_i,
  output logic [CRC_W-1:0] bnd_o
);
  logic [CRC_W-1:0] crc_q, bnd_q, crc_base, bnd_base, crc_nxt;
  logic             fb;

  assign crc_base = start_i ? CRC_INIT : crc_q;
  assign bnd_base = start_i ? CRC_INIT : bnd_q;
  assign fb       = crc_base[CRC_W-1] ^ bit_i;
  assign crc_nxt  = {crc_base[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  // boundary value as of this bit: fresh if it closes an octet, else last snapshot
  assign bnd_o    = (bit_en_i && oct_end_i) ? crc_nxt : bnd_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= CRC_INIT;
      bnd_q <= CRC_INIT;
    end else if (bit_en_i) begin
      crc_q <= crc_nxt;
      bnd_q <= bnd_o;
    end
  end

  p_bnd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !oct_end_i && !start_i |=> bnd_q == $past(bnd_q));
endmodule

// File: rtl/eth_rx_framer.sv
module eth_rx_framer
  import eth_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              eof_i,
  input  logic              crc_bad_i,
  output logic              take_o,
  output logic              start_o,
  output logic              oct_end_o,
  output logic              close_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DRIB_W-1:0] drib_o
);
  localparam logic [LEN_W-1:0]  LEN_MAX  = '1;
  localparam logic [DRIB_W-1:0] IDX_LAST = '1;

  rx_state_e         state_q, state_d;
  logic [DRIB_W-1:0] idx_q, idx_base;
  logic [LEN_W-1:0]  oct_q, oct_base, oct_inc;

  assign take_o    = valid_i && (state_q != ST_HUNT);
  assign start_o   = take_o && (state_q == ST_IDLE);
  assign idx_base  = start_o ? '0 : idx_q;
  assign oct_base  = start_o ? '0 : oct_q;
  assign oct_end_o = (idx_base == IDX_LAST);
  assign oct_inc   = !oct_end_o ? oct_base :
                     (oct_base == LEN_MAX) ? oct_base : oct_base + 1'b1;
  assign close_o   = take_o && eof_i;
  assign len_o     = oct_inc;
  assign drib_o    = oct_end_o ? '0 : idx_base + 1'b1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_RECV: begin
        if (close_o)     state_d = crc_bad_i ? ST_HUNT : ST_IDLE;
        else if (take_o) state_d = ST_RECV;
      end
      ST_HUNT:  if (!valid_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      oct_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take_o) begin
        idx_q <= idx_base + 1'b1;
        oct_q <= oct_inc;
      end
    end
  end

  p_hunt_enter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o && crc_bad_i |=> !close_o);
  p_hunt_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT) && valid_i |=> state_q == ST_HUNT);
endmodule

// File: rtl/eth_rx_sat_cnt.sv
module eth_rx_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && cnt_q == MAX |=> cnt_q == MAX);
  p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && cnt_q != MAX |=> cnt_q == $past(cnt_q) + 1'b1);
  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/eth_rx_err_chk.sv
module eth_rx_err_chk
  import eth_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_bit_i,
  input  logic              rx_valid_i,
  input  logic              rx_eof_i,
  input  logic              short_ok_i,
  input  logic [LEN_W-1:0]  min_len_i,
  input  logic              cnt_clr_i,
  output logic              done_o,
  output logic              rx_evt_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [CNT_W-1:0]  crc_cnt_o,
  output logic [CNT_W-1:0]  aln_cnt_o
);
  logic              take, start, oct_end, close;
  logic [LEN_W-1:0]  len;
  logic [DRIB_W-1:0] drib;
  logic [CRC_W-1:0]  bnd;
  logic              crc_bad, short_f, accept, inc_crc, inc_aln;
  rx_stat_t          st_d, st_q;
  logic              done_q, evt_q;

  eth_rx_framer u_framer (
    .clk_i, .rst_ni,
    .valid_i   (rx_valid_i),
    .eof_i     (rx_eof_i),
    .crc_bad_i (crc_bad),
    .take_o    (take),
    .start_o   (start),
    .oct_end_o (oct_end),
    .close_o   (close),
    .len_o     (len),
    .drib_o    (drib)
  );

  eth_rx_crc u_crc (
    .clk_i, .rst_ni,
    .start_i   (start),
    .bit_en_i  (take),
    .bit_i     (rx_bit_i),
    .oct_end_i (oct_end),
    .bnd_o     (bnd)
  );

  assign crc_bad = (bnd != CRC_GOOD);
  assign short_f = (len < min_len_i);
  assign accept  = !short_f || short_ok_i;

  always_comb begin
    st_d.len       = len;
    st_d.drib      = drib;
    st_d.short_f   = short_f;
    st_d.crc_err   = crc_bad;
    st_d.align_err = crc_bad && (drib != '0);
    st_d.accept    = accept;
  end

  // alignment error takes the count alone
  assign inc_aln = close && accept && st_d.align_err;
  assign inc_crc = close && accept && crc_bad && !st_d.align_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      done_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      done_q <= close;
      evt_q  <= close && accept;
      if (close) st_q <= st_d;
    end
  end

  eth_rx_sat_cnt #(.W(CNT_W)) u_crc_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr_i), .inc_i(inc_crc), .cnt_o(crc_cnt_o)
  );
  eth_rx_sat_cnt #(.W(CNT_W)) u_aln_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr_i), .inc_i(inc_aln), .cnt_o(aln_cnt_o)
  );

  assign done_o   = done_q;
  assign rx_evt_o = evt_q;
  assign stat_o   = st_q;

  p_evt_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_o |-> done_o);
  p_discard_short_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !st_q.accept |-> st_q.short_f && !rx_evt_o);
  p_align_crc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && st_q.align_err |-> st_q.crc_err && st_q.drib != '0);
  p_aln_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && st_q.align_err && !$past(cnt_clr_i) |-> crc_cnt_o == $past(crc_cnt_o));
  p_stat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close |=> $stable(st_q));
endmodule

// File: tb/eth_rx_err_chk_test.sv
`timescale 1ns/1ps
module eth_rx_err_chk_test;
  import eth_rx_pkg::*;

  localparam int CW = 4;
  localparam int NB = 16384;
  localparam int NE = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_bit = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, short_ok = 1'b0, clr = 1'b0;
  logic [LEN_W-1:0] min_len = 16'd64;
  logic done, evt;
  logic [STAT_W-1:0] stat;
  logic [CW-1:0] crc_cnt, aln_cnt;

  always #4 clk = ~clk;

  eth_rx_err_chk #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .rx_valid_i(rx_valid),
    .rx_eof_i(rx_eof), .short_ok_i(short_ok), .min_len_i(min_len),
    .cnt_clr_i(clr), .done_o(done), .rx_evt_o(evt), .stat_o(stat),
    .crc_cnt_o(crc_cnt), .aln_cnt_o(aln_cnt)
  );

  int checks = 0, fails = 0;
  logic b_a[NB], e_a[NB], v_a[NB], c_a[NB];
  int nb = 0;
  logic [STAT_W-1:0] exp_st[NE];
  string exp_rq[NE];
  int ne = 0, ng = 0;
  int m_crc = 0, m_aln = 0;
  localparam int CMAX = (1 << CW) - 1;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, ex);
    end
  endtask

  task automatic push(input logic b, input logic e, input logic v, input logic c);
    b_a[nb] = b; e_a[nb] = e; v_a[nb] = v; c_a[nb] = c; nb++;
  endtask

  task automatic expect_frame(input int len, input int drib, input bit bad,
                              input bit seen, input bit clr_eof, input string rq);
    logic sh, acc, aln;
    sh  = (len < int'(min_len));
    acc = !sh || short_ok;
    aln = bad && (drib != 0);
    if (seen) begin
      exp_st[ne] = {16'(len), 3'(drib), sh, aln, bad, acc};
      exp_rq[ne] = rq;
      ne++;
      if (clr_eof) begin m_crc = 0; m_aln = 0; end
      else if (acc && bad) begin
        if (aln) m_aln = (m_aln < CMAX) ? m_aln + 1 : CMAX;
        else     m_crc = (m_crc < CMAX) ? m_crc + 1 : CMAX;
      end
    end
  endtask

  // payload of n octets, reflected CRC-32 FCS, then drib extra bits
  task automatic frame(input int n, input int seed, input int drib, input bit bad,
                       input bit gap, input bit seen, input string rq);
    logic [31:0] r, fcs;
    logic [7:0] by;
    logic bt;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      by = 8'((seed * 13 + k * 37 + 5) & 255);
      for (int j = 0; j < 8; j++) begin
        bt = by[j];
        push(bt, 1'b0, 1'b1, 1'b0);
        r = (r >> 1) ^ (((r[0] ^ bt) == 1'b1) ? 32'hEDB8_8320 : 32'h0);
      end
    end
    fcs = ~r;
    if (bad) fcs[5] = ~fcs[5];
    for (int j = 0; j < 32; j++) push(fcs[j], 1'b0, 1'b1, 1'b0);
    for (int j = 0; j < drib; j++) push(1'((seed >> j) & 1), 1'b0, 1'b1, 1'b0);
    e_a[nb-1] = 1'b1;
    if (gap) push(1'b0, 1'b0, 1'b0, 1'b0);
    expect_frame(n + 4, drib, bad, seen, 1'b0, rq);
  endtask

  // one bit then end: zero octets, one dribble bit, boundary CRC is the preset
  task automatic tiny(input bit clr_eof, input string rq);
    push(1'b1, 1'b1, 1'b1, clr_eof);
    push(1'b0, 1'b0, 1'b0, 1'b0);
    expect_frame(0, 1, 1'b1, 1'b1, clr_eof, rq);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (ng < ne) begin
        chk(stat == exp_st[ng], exp_rq[ng], 32'(stat), 32'(exp_st[ng]));
        chk(evt == exp_st[ng][0], "R5", 32'(evt), 32'(exp_st[ng][0]));
      end else begin
        chk(1'b0, "R6 unexpected frame", 32'(stat), 32'h0);
      end
      ng++;
    end
  end

  task automatic play(input string rq);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rx_bit = b_a[i]; rx_eof = e_a[i]; rx_valid = v_a[i]; clr = c_a[i];
    end
    @(negedge clk);
    rx_bit = 1'b0; rx_eof = 1'b0; rx_valid = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(ng == ne, {rq, " frame count"}, 32'(ng), 32'(ne));
    chk(crc_cnt == CW'(m_crc), {rq, " crc counter"}, 32'(crc_cnt), 32'(m_crc));
    chk(aln_cnt == CW'(m_aln), {rq, " aln counter"}, 32'(aln_cnt), 32'(m_aln));
    nb = 0; ne = 0; ng = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(stat == '0 && !done && !evt, "R11 reset state", 32'(stat), 32'h0);
    chk(crc_cnt == '0 && aln_cnt == '0, "R11 reset counters", 32'({crc_cnt, aln_cnt}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 good aligned frames of several lengths and contents
    frame(60, 1, 0, 1'b0, 1'b1, 1'b1, "R1");
    frame(100, 7, 0, 1'b0, 1'b1, 1'b1, "R1");
    frame(61, 200, 0, 1'b0, 1'b1, 1'b1, "R1");
    play("R1");

    // R2 / R3 every dribble count, good then corrupted FCS
    for (int d = 1; d < 8; d++) frame(60, d * 3, d, 1'b0, 1'b1, 1'b1, "R2");
    for (int d = 1; d < 8; d++) frame(60, d * 5, d, 1'b1, 1'b1, 1'b1, "R3");
    play("R3");

    // R4 aligned CRC errors
    frame(60, 9, 0, 1'b1, 1'b1, 1'b1, "R4");
    frame(70, 11, 0, 1'b1, 1'b1, 1'b1, "R4");
    play("R4");

    // R7 short frames discarded, good and bad
    frame(10, 3, 0, 1'b0, 1'b1, 1'b1, "R7");
    frame(10, 4, 0, 1'b1, 1'b1, 1'b1, "R7");
    frame(59, 5, 2, 1'b1, 1'b1, 1'b1, "R7");
    play("R7");

    // R8 short frames delivered
    short_ok = 1'b1;
    frame(10, 3, 0, 1'b0, 1'b1, 1'b1, "R8");
    frame(12, 6, 0, 1'b1, 1'b1, 1'b1, "R8");
    frame(20, 8, 4, 1'b1, 1'b1, 1'b1, "R8");
    play("R8");
    short_ok = 1'b0;

    // R6 back-to-back after good frame is received; after bad one it is dropped
    frame(60, 21, 0, 1'b0, 1'b0, 1'b1, "R6");
    frame(60, 22, 0, 1'b0, 1'b1, 1'b1, "R6");
    frame(60, 23, 0, 1'b1, 1'b0, 1'b1, "R6");
    frame(60, 24, 0, 1'b0, 1'b0, 1'b0, "R6");
    frame(60, 25, 3, 1'b1, 1'b1, 1'b0, "R6");
    frame(60, 26, 0, 1'b0, 1'b1, 1'b1, "R6");
    play("R6");

    // R10 idle clear
    push(1'b0, 1'b0, 1'b0, 1'b1);
    m_crc = 0; m_aln = 0;
    play("R10");

    // R9 saturation of the alignment counter
    short_ok = 1'b1;
    for (int i = 0; i < 20; i++) tiny(1'b0, "R9");
    play("R9");

    // R10 clear on the same edge as a counted error
    tiny(1'b1, "R10");
    play("R10");
    tiny(1'b0, "R10");
    play("R10");
    short_ok = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule